// File: doc/BRIEF.md
# Redundant Successive-Approximation Conversion Sequencer

This block runs the bit-cycling phase of a 10-bit successive-approximation converter that takes twelve decisions instead of ten. The extra decisions come from a non-binary weight set (384, 256, 128, 112, 64, 32, 16, 16, 8, 4, 2, 1, total 1023). Because of this, a decision that comes out too low in an early cycle, for example because the capacitor array had not settled, is made up by the later cycles. A conversion starts when the sampled level of the sample clock goes from high to low. Each cycle has an acceptance window. The window takes exactly one comparator decision, on the rising edge of the comparator-ready strobe, and then locks it. The next window opens only after the strobe has returned low, which marks the end of the comparator's reset phase.

Every locked decision moves one element of one capacitor array, and the move is one-way. A decision of 1 means the P side is higher, so the P array element for that cycle is switched to the low reference. A decision of 0 switches the N array element instead. After the twelfth decision, the sequencer adds up the weights of the cycles that decided 1, clamps the sum to ten bits, registers it as the output code and raises a done flag. If a window stays open for a programmable number of clock edges without a strobe, a decision of 0 is forced so that the conversion cannot stall. A new falling sample edge at any time aborts the current conversion and starts a fresh one.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, every switch control, the done flag and the code are cleared to 0.
- R2: A clock edge that sees samp_clk low, after the previous edge saw it high, opens the window for cycle 1. A strobe rise at the very next edge is accepted.
- R3: In an open window, a rising edge of cmp_rdy (low at the previous edge, high now) locks cmp_p as the decision. Decision 1 sets sw_p bit k-1 and decision 0 sets sw_n bit k-1, where k is the cycle number from 1 to 12. At most one bit changes per edge.
- R4: A switch bit that has been set stays set until the next falling sample edge.
- R5: After a decision, the next window opens only at an edge that sees cmp_rdy low. Strobe rises while no window is open change nothing.
- R6: conv_done rises at the edge that locks the twelfth decision and stays high until the next falling sample edge. At that point all twelve cycles have one switch bit set.
- R7: code is the sum of the weights 384, 256, 128, 112, 64, 32, 16, 16, 8, 4, 2, 1 (cycles 1 to 12) over the cycles that decided 1. It is clamped to 1023 and registered when conv_done rises, and it holds until the next completion.
- R8: With an ideal weighted array, where the comparator reports 1 when its input is at least the committed weights plus the current cycle's weight, the code equals the input value. This still holds when the comparator input is understated by less than the cycle's tolerance. The tolerances for cycles 1 to 7 are 256, 128, 128, 32, 16, 16 and 16 LSB, and cycles 8 to 12 tolerate no error.
- R9: If a window sees no strobe rise by the tmo_lim-th edge after it opened, that edge forces decision 0 (sw_n is set) and the sequence continues. A tmo_lim of 0 disables the timeout.
- R10: A falling sample edge during a conversion clears all switch bits and conv_done at that edge and reopens the window for cycle 1.
- R11: sw_p and sw_n never have the same bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_clk | input | 1 | Sample clock level; a high-to-low change starts a conversion |
| cmp_p | input | 1 | Comparator decision, 1 when the P side is higher |
| cmp_rdy | input | 1 | Comparator-ready strobe; a rise marks a valid decision |
| tmo_lim | input | 8 | Window timeout in clock edges, 0 disables it |
| sw_p | output | 12 | P array switch controls, bit k-1 for cycle k |
| sw_n | output | 12 | N array switch controls, bit k-1 for cycle k |
| conv_done | output | 1 | Conversion finished; code is valid |
| code | output | 10 | Recombined output code |

## Verification
The assertions assume that samp_clk and cmp_rdy are already synchronous to clk. They also assume that cmp_rdy drops between decisions, because a strobe held high would never open the next window. The stimulus always changes these inputs half a period away from the active edge, and it holds the strobe low for at least one edge after each decision. Settling errors are injected only in the understating direction and always below each cycle's tolerance. Timeout and abort cases are produced deliberately by withholding strobes or by re-pulsing the sample clock mid-conversion.

// File: rtl/sar_seq_pkg.sv
// Package: shared types and the cycle weight set of the conversion sequencer.
// Assumes cycle indices count from 0 for the first (heaviest) decision.
package sar_seq_pkg;

    // Sequencer phases: idle, window open, waiting for comparator reset, finished.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WIN  = 2'd1,
        PH_REST = 2'd2,
        PH_DONE = 2'd3
    } phase_t;

    // Weight of decision cycle i in output LSBs; the twelve values add up to 1023.
    function automatic int cyc_weight(input int i);
        case (i)
            0:       return 384;
            1:       return 256;
            2:       return 128;
            3:       return 112;
            4:       return 64;
            5:       return 32;
            6:       return 16;
            7:       return 16;
            8:       return 8;
            9:       return 4;
            10:      return 2;
            11:      return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/sar_edge_det.sv
// Module: single-edge detector for a signal already synchronous to clk.
// Produces a one-cycle combinational pulse when the current level differs from
// the registered previous level in the chosen direction. Previous level resets to 0.
module sar_edge_det #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);

    logic prev_q;

    // Remember the level seen at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= din;
    end

    generate
        if (FALLING) begin : g_fall
            // High-to-low transition.
            assign pulse = prev_q & ~din;
        end else begin : g_rise
            // Low-to-high transition.
            assign pulse = ~prev_q & din;
        end
    endgenerate

endmodule

// File: rtl/sar_win_timer.sv
// Module: window watchdog. Counts clock edges while a window is open and flags
// the edge on which the window has been open for lim edges. lim of 0 never fires.
// Assumes run drops for at least one edge between consecutive windows.
module sar_win_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] lim,
    output logic             hit
);

    localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

    logic [TMO_W-1:0] cnt_q;

    // Count edges spent in the open window, saturating, cleared when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)      cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Expiry on the lim-th edge of the window.
    assign hit = run && (lim != '0) && (cnt_q == lim - 1'b1);

endmodule

// File: rtl/sar_recomb.sv
// Module: non-binary recombination. Adds the weight of every cycle whose
// decision is 1 and clamps the total to the output width. Purely combinational.
module sar_recomb #(
    parameter int NCYC  = 12,
    parameter int OUT_W = 10
) (
    input  logic [NCYC-1:0]  dec,
    output logic [OUT_W-1:0] code
);

    import sar_seq_pkg::*;

    localparam int SUM_W = OUT_W + 3;
    localparam logic [SUM_W-1:0] CODE_MAX = SUM_W'((1 << OUT_W) - 1);

    logic [SUM_W-1:0] part [NCYC+1];

    assign part[0] = '0;

    generate
        for (genvar g = 0; g < NCYC; g++) begin : g_acc
            localparam logic [SUM_W-1:0] WG = SUM_W'(cyc_weight(g));
            // Running sum stage for cycle g.
            assign part[g+1] = part[g] + (dec[g] ? WG : '0);
        end
    endgenerate

    // Clamp the total into the output range.
    assign code = (part[NCYC] > CODE_MAX) ? OUT_W'(CODE_MAX) : OUT_W'(part[NCYC]);

endmodule

// File: rtl/sar_seq_ctrl.sv
// Module: redundant successive-approximation sequencer (top).
// A falling sample level starts NCYC decision cycles. Each cycle opens a window
// that locks the comparator decision on the strobe's rising edge (or forces 0 on
// timeout), sets one monotonic switch bit, then waits for the strobe to go low
// before the next window. The last decision registers the recombined code.
// Assumes samp_clk, cmp_p and cmp_rdy are synchronous to clk.
module sar_seq_ctrl #(
    parameter int NCYC  = 12,
    parameter int OUT_W = 10,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_clk,
    input  logic             cmp_p,
    input  logic             cmp_rdy,
    input  logic [TMO_W-1:0] tmo_lim,
    output logic [NCYC-1:0]  sw_p,
    output logic [NCYC-1:0]  sw_n,
    output logic             conv_done,
    output logic [OUT_W-1:0] code
);

    import sar_seq_pkg::*;

    localparam int IDX_W = $clog2(NCYC);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCYC - 1);

    phase_t           phase_q;
    logic [IDX_W-1:0] idx_q;
    logic [NCYC-1:0]  swp_q, swn_q;
    logic [NCYC-1:0]  swp_nxt, swn_nxt;
    logic             done_q;
    logic [OUT_W-1:0] code_q;
    logic [OUT_W-1:0] code_nxt;
    logic             samp_fall, rdy_rise, tmo_hit;
    logic             take, d_bit, win_run;

    // Start-of-conversion detector on the sample level.
    sar_edge_det #(.FALLING(1'b1)) i_samp_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (samp_clk),
        .pulse (samp_fall)
    );

    // Decision-ready detector on the comparator strobe.
    sar_edge_det #(.FALLING(1'b0)) i_rdy_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cmp_rdy),
        .pulse (rdy_rise)
    );

    assign win_run = (phase_q == PH_WIN) && !samp_fall;

    // Stall guard for the open window.
    sar_win_timer #(.TMO_W(TMO_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (win_run),
        .lim   (tmo_lim),
        .hit   (tmo_hit)
    );

    // Lock condition and locked value for the current window.
    always_comb begin
        take  = win_run && (rdy_rise || tmo_hit);
        d_bit = rdy_rise & cmp_p;
    end

    // Next switch state: only the current cycle's element may move.
    always_comb begin
        for (int i = 0; i < NCYC; i++) begin
            if (take && (IDX_W'(i) == idx_q)) begin
                swp_nxt[i] = d_bit;
                swn_nxt[i] = ~d_bit;
            end else begin
                swp_nxt[i] = swp_q[i];
                swn_nxt[i] = swn_q[i];
            end
        end
    end

    // Weighted recombination of the decisions including the one being locked.
    sar_recomb #(.NCYC(NCYC), .OUT_W(OUT_W)) i_recomb (
        .dec  (swp_nxt),
        .code (code_nxt)
    );

    // Phase sequencing, switch state, done flag and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            swp_q   <= '0;
            swn_q   <= '0;
            done_q  <= 1'b0;
            code_q  <= '0;
        end else if (samp_fall) begin
            phase_q <= PH_WIN;
            idx_q   <= '0;
            swp_q   <= '0;
            swn_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            swp_q <= swp_nxt;
            swn_q <= swn_nxt;
            case (phase_q)
                PH_WIN: begin
                    if (take) begin
                        if (idx_q == LAST_IDX) begin
                            phase_q <= PH_DONE;
                            done_q  <= 1'b1;
                            code_q  <= code_nxt;
                        end else begin
                            phase_q <= PH_REST;
                        end
                    end
                end
                PH_REST: begin
                    if (!cmp_rdy) begin
                        phase_q <= PH_WIN;
                        idx_q   <= idx_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= phase_q;
                end
            endcase
        end
    end

    assign sw_p      = swp_q;
    assign sw_n      = swn_q;
    assign conv_done = done_q;
    assign code      = code_q;

endmodule

// File: rtl/sar_seq_ctrl_chk.sv
// Module: property checker for the sequencer, attached by bind.
// Keeps its own registered copy of the sample level to spot falling edges.
module sar_seq_ctrl_chk #(
    parameter int NCYC = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            samp_clk,
    input logic [NCYC-1:0] sw_p,
    input logic [NCYC-1:0] sw_n,
    input logic            conv_done
);

    logic samp_prev;
    logic fall_now;

    // Previous sample level, reset low like the design's detector.
    always_ff @(posedge clk) begin
        if (!rst_n) samp_prev <= 1'b0;
        else        samp_prev <= samp_clk;
    end

    assign fall_now = samp_prev && !samp_clk;

    // R11: an element never moves on both arrays.
    p_one_side_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_p & sw_n) == '0);

    // R4: set bits stay set unless a new conversion starts.
    p_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_now |=> (((sw_p | sw_n) & $past(sw_p | sw_n)) == $past(sw_p | sw_n)));

    // R3: at most one element moves per edge.
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_now |=> ($countones(sw_p | sw_n) <= $countones($past(sw_p | sw_n)) + 1));

    // R10: a falling sample edge clears the arrays and the done flag.
    p_abort_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fall_now |=> (sw_p == '0 && sw_n == '0 && !conv_done));

    // R6: done implies every cycle has moved exactly one element.
    p_done_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> ($countones(sw_p | sw_n) == NCYC));

    // R6: done holds until a new conversion starts.
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !fall_now) |=> conv_done);

endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.NCYC(NCYC)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_clk  (samp_clk),
    .sw_p      (sw_p),
    .sw_n      (sw_n),
    .conv_done (conv_done)
);

// File: tb/test_sar_seq_ctrl.sv
// Bench: behavioural reference model compared on every clock, plus an ideal
// weighted-array comparator model with injected understating settling errors.
module test_sar_seq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_clk = 1'b0;
    logic        cmp_p = 1'b0;
    logic        cmp_rdy = 1'b0;
    logic [7:0]  tmo_lim = 8'd50;
    logic [11:0] sw_p, sw_n;
    logic        conv_done;
    logic [9:0]  code;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int wt  [12] = '{384, 256, 128, 112, 64, 32, 16, 16, 8, 4, 2, 1};
    int tol [12] = '{256, 128, 128, 32, 16, 16, 16, 0, 0, 0, 0, 0};

    always #10 clk = ~clk;   // 50 MHz

    sar_seq_ctrl i_sar_seq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_clk  (samp_clk),
        .cmp_p     (cmp_p),
        .cmp_rdy   (cmp_rdy),
        .tmo_lim   (tmo_lim),
        .sw_p      (sw_p),
        .sw_n      (sw_n),
        .conv_done (conv_done),
        .code      (code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit          m_sq, m_rq, m_fall, m_rise, m_dv, m_started;
    int          m_ph, m_idx, m_cnt, m_sum;
    logic [11:0] m_swp, m_swn;
    bit          m_done;
    int          m_code;

    always @(posedge clk) begin
        m_started = 1'b1;
        if (!rst_n) begin
            m_sq = 0; m_rq = 0; m_ph = 0; m_idx = 0; m_cnt = 0;
            m_swp = '0; m_swn = '0; m_done = 0; m_code = 0;
        end else begin
            m_fall = m_sq && !samp_clk;
            m_rise = cmp_rdy && !m_rq;
            if (m_fall) begin
                m_ph = 1; m_idx = 0; m_cnt = 0; m_swp = '0; m_swn = '0; m_done = 0;
            end else if (m_ph == 1) begin
                if (m_rise || (tmo_lim != 0 && m_cnt == int'(tmo_lim) - 1)) begin
                    m_dv = m_rise ? cmp_p : 1'b0;
                    if (m_dv) m_swp[m_idx] = 1'b1;
                    else      m_swn[m_idx] = 1'b1;
                    m_cnt = 0;
                    if (m_idx == 11) begin
                        m_ph = 3; m_done = 1; m_sum = 0;
                        for (int j = 0; j < 12; j++) if (m_swp[j]) m_sum += wt[j];
                        m_code = (m_sum > 1023) ? 1023 : m_sum;
                    end else begin
                        m_ph = 2;
                    end
                end else if (m_cnt < 255) begin
                    m_cnt++;
                end
            end else if (m_ph == 2) begin
                if (!cmp_rdy) begin m_ph = 1; m_idx++; m_cnt = 0; end
            end
            m_sq = samp_clk;
            m_rq = cmp_rdy;
        end
    end

    // Compare the design against the model away from the active edge.
    always @(negedge clk) begin
        if (m_started && !finished) begin
            chk(sw_p == m_swp && sw_n == m_swn, "R3 switch state vs model",
                int'({sw_p, sw_n}), int'({m_swp, m_swn}));
            chk(conv_done == m_done, "R6 done vs model", int'(conv_done), int'(m_done));
            chk(int'(code) == m_code, "R7 code vs model", int'(code), m_code);
        end
    end

    // ---------------- comparator / array model ----------------
    function automatic bit cmp_decide(input int vin, input int err, input int i);
        int thr = wt[i];
        for (int j = 0; j < i; j++) if (sw_p[j]) thr += wt[j];
        return (vin - err) >= thr;
    endfunction

    function automatic int pick_err(input int mode, input int i);
        if (tol[i] == 0) return 0;
        case (mode)
            1:       return tol[i] - 1;
            2:       return (i % 2 == 0) ? (tol[i] - 1) / 2 : tol[i] - 1;
            default: return 0;
        endcase
    endfunction

    task automatic start_sample();
        samp_clk = 1'b1;
        repeat (2) @(negedge clk);
        samp_clk = 1'b0;
        @(negedge clk);
    endtask

    // One comparator decision for cycle i: strobe for one edge, then low for gap edges.
    task automatic decide(input int vin, input int err, input int i, input int gap);
        cmp_p   = cmp_decide(vin, err, i);
        cmp_rdy = 1'b1;
        @(negedge clk);
        cmp_rdy = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic convert(input int vin, input int mode, input int gap, input string tag);
        start_sample();
        for (int i = 0; i < 12; i++) begin
            decide(vin, pick_err(mode, i), i, gap);
            if (i == 0)
                chk($countones(sw_p | sw_n) == 1, "R2 first window open after sample fall",
                    $countones(sw_p | sw_n), 1);
        end
        repeat (2) @(negedge clk);
        chk(conv_done == 1'b1, "R6 done after twelve decisions", int'(conv_done), 1);
        chk(int'(code) == vin, tag, int'(code), vin);
        chk((sw_p & sw_n) == 12'd0, "R11 no element on both sides", int'(sw_p & sw_n), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [11:0] hold_p, hold_n;
        int          hold_code;

        repeat (3) @(negedge clk);
        chk(sw_p == 12'd0 && sw_n == 12'd0, "R1 switches clear in reset", int'(sw_p | sw_n), 0);
        chk(conv_done == 1'b0, "R1 done clear in reset", int'(conv_done), 0);
        chk(code == 10'd0, "R1 code clear in reset", int'(code), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7/R8: ideal array, various inputs and strobe spacings.
        convert(0,    0, 1, "R8 ideal code 0");
        convert(1023, 0, 1, "R8 ideal code 1023");
        convert(512,  0, 2, "R8 ideal code 512");
        convert(384,  0, 1, "R7 code 384 (first weight only)");
        convert(700,  0, 3, "R8 ideal code 700");
        convert(127,  0, 1, "R8 ideal code 127");

        // R8: understating settling errors within the tolerance of each cycle.
        convert(1023, 1, 1, "R8 max tolerated error, 1023");
        convert(640,  1, 1, "R8 max tolerated error, 640");
        convert(383,  2, 2, "R8 mixed tolerated error, 383");
        convert(511,  1, 1, "R8 max tolerated error, 511");
        convert(850,  2, 1, "R8 mixed tolerated error, 850");

        // R4: every cycle still holds its element at completion.
        chk($countones(sw_p | sw_n) == 12, "R4 all moved elements still set",
            $countones(sw_p | sw_n), 12);

        // R5: strobe rises after completion change nothing.
        hold_p = sw_p; hold_n = sw_n; hold_code = int'(code);
        cmp_p = 1'b1; cmp_rdy = 1'b1; @(negedge clk); cmp_rdy = 1'b0; @(negedge clk);
        cmp_p = 1'b0; cmp_rdy = 1'b1; @(negedge clk); cmp_rdy = 1'b0; repeat (2) @(negedge clk);
        chk(sw_p == hold_p && sw_n == hold_n, "R5 strobe ignored when done",
            int'(sw_p), int'(hold_p));
        chk(int'(code) == hold_code && conv_done, "R5 code kept when done", int'(code), hold_code);

        // R5: strobe held high after a decision keeps the next window closed.
        start_sample();
        cmp_p = 1'b1; cmp_rdy = 1'b1;
        repeat (6) @(negedge clk);
        chk($countones(sw_p | sw_n) == 1, "R5 no second decision while strobe high",
            $countones(sw_p | sw_n), 1);
        cmp_rdy = 1'b0;
        @(negedge clk);
        for (int i = 1; i < 12; i++) decide(1000, 0, i, 1);
        repeat (2) @(negedge clk);
        chk(int'(code) == 1000, "R8 code after held strobe", int'(code), 1000);

        // R9: timeout forces decision 0 on cycle 3; redundancy recovers the value.
        tmo_lim = 8'd4;
        start_sample();
        for (int i = 0; i < 12; i++) begin
            if (i == 2) begin
                repeat (8) @(negedge clk);
                chk(sw_n[2] == 1'b1 && sw_p[2] == 1'b0, "R9 timeout forced decision 0",
                    int'({sw_p[2], sw_n[2]}), 1);
            end else begin
                decide(200, 0, i, 1);
            end
        end
        repeat (2) @(negedge clk);
        chk(int'(code) == 200, "R9 code after forced decision", int'(code), 200);

        // R9: limit 0 disables the timeout.
        tmo_lim = 8'd0;
        start_sample();
        repeat (300) @(negedge clk);
        chk((sw_p | sw_n) == 12'd0, "R9 no forced decision with limit 0",
            int'(sw_p | sw_n), 0);
        for (int i = 0; i < 12; i++) decide(333, 0, i, 1);
        repeat (2) @(negedge clk);
        chk(int'(code) == 333, "R8 code after long wait", int'(code), 333);
        tmo_lim = 8'd50;

        // R10: abort mid-conversion and restart.
        start_sample();
        for (int i = 0; i < 5; i++) decide(600, 0, i, 1);
        samp_clk = 1'b1; @(negedge clk);
        samp_clk = 1'b0; @(negedge clk);
        chk((sw_p | sw_n) == 12'd0, "R10 abort clears switches", int'(sw_p | sw_n), 0);
        chk(conv_done == 1'b0, "R10 abort clears done", int'(conv_done), 0);
        for (int i = 0; i < 12; i++) decide(77, 0, i, 1);
        repeat (2) @(negedge clk);
        chk(int'(code) == 77 && conv_done, "R10 fresh conversion after abort", int'(code), 77);

        // R10: a new sample after completion clears done.
        samp_clk = 1'b1; @(negedge clk);
        samp_clk = 1'b0; @(negedge clk);
        chk(conv_done == 1'b0, "R10 done cleared by new sample", int'(conv_done), 0);
        chk(int'(code) == 77, "R7 code held until next completion", int'(code), 77);
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule